// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two two's-complement operands and a carry-in with no clock. The operand width is split into fixed-size groups. Every bit forms a generate and a propagate term. Each group works out all of its internal carries as flattened sum-of-products expressions from those terms and its own carry-in. Each group also reports one propagate and one generate term for the group as a whole.

A second-level lookahead unit takes the group terms and the external carry-in and forms the carry into every group, plus the final carry-out. No carry ripples from one group to the next. Both levels use the same lookahead module. The block has three outputs: the sum, the unsigned carry-out and a signed overflow flag.

The block fits into a datapath wherever an adder with short, even carry paths is needed. It holds no state, so its outputs follow its inputs within the same cycle.

Top module: `cla2_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^WIDTH for every pair of operands and both values of `cin`.
- R2: `cout` equals bit WIDTH of the full unsigned sum `a` + `b` + `cin`.
- R3: `ovf` is 1 exactly when the carry into the most significant bit differs from the carry out of it. This is the same as both operands having equal sign bits while `sum` has the other sign bit.
- R4: The carry the second-level unit gives to each group equals the carry-out that the group below forms from its own flattened equations.
- R5: When every bit of a group propagates (each bit has a differing from b), the group's carry-out equals its carry-in. This holds at the top level too: `a` = ~`b` gives `cout` = `cin` and `sum` = all ones xor `cin` replicated.
- R6: When a group generates a carry, its carry-out is 1 whatever its carry-in.
- R7: The longest carry path gives correct results: all ones plus one, and all ones plus zero with `cin` = 1, both give a zero sum with `cout` = 1.
- R8: The block is purely combinational. A new operand pair shows at the outputs before any clock edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, two's complement |
| b | input | WIDTH | Second operand, two's complement |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Signed overflow flag |

## Verification
The hardest case to reach is a carry that must travel through every group on its propagate path alone. A group-level propagate term then has to pass the external carry-in through the second-level unit into all groups. Random operands make this almost never happen, because every one of the sixteen bit pairs must differ. The stimulus therefore uses complementary patterns such as 0xAAAA with 0x5555, and all ones with one, under both carry-in values. It adds operands that cross each group boundary, and signed extremes that force overflow in both directions.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
   // Largest span one lookahead level may flatten; bounds the SOP size.
   localparam int CLA2_MAX_SPAN = 16;
endpackage

// File: rtl/cla2_bit_pg.sv
module cla2_bit_pg #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] gen,
   output logic [W-1:0] prop
);
   generate
      if (W < 1) begin : g_bad_w
         $error("cla2_bit_pg: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gen[i]  = a[i] & b[i];
      assign prop[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/cla2_lookahead.sv
module cla2_lookahead #(
   parameter int N = 4
) (
   input  logic [N-1:0] gen,
   input  logic [N-1:0] prop,
   input  logic         c0,
   output logic [N:0]   c,
   output logic         blk_p,
   output logic         blk_g
);
   import cla2_pkg::*;

   generate
      if (N < 1 || N > CLA2_MAX_SPAN) begin : g_bad_n
         $error("cla2_lookahead: N out of range");
      end
   endgenerate

   // Carry into position pos, as one flat OR of AND terms:
   // G[j] P[j+1]..P[pos-1] for every j below pos, plus P[0]..P[pos-1] c0.
   function automatic logic carry_at(input logic [N-1:0] gv,
                                     input logic [N-1:0] pv,
                                     input logic         cv,
                                     input int           pos);
      logic acc;
      logic prod;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         if (j < pos) begin
            prod = gv[j];
            for (int k = 0; k < N; k++) begin
               if (k > j && k < pos) prod = prod & pv[k];
            end
            acc = acc | prod;
         end
      end
      prod = cv;
      for (int k = 0; k < N; k++) begin
         if (k < pos) prod = prod & pv[k];
      end
      return acc | prod;
   endfunction

   assign c[0] = c0;
   for (genvar i = 1; i <= N; i++) begin : g_carry
      assign c[i] = carry_at(gen, prop, c0, i);
   end

   assign blk_p = &prop;
   assign blk_g = carry_at(gen, prop, 1'b0, N);

   always_comb begin
      assert_blk_gen_R6: assert (!blk_g || c[N])
         else $error("block generate without carry-out");
      assert_blk_prop_R5: assert (!blk_p || (c[N] == c0))
         else $error("block propagate but carry-out differs from carry-in");
   end
endmodule

// File: rtl/cla2_group.sv
module cla2_group #(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          cin,
   output logic [GW-1:0] sum,
   output logic          grp_p,
   output logic          grp_g,
   output logic          c_msb,
   output logic          c_out
);
   logic [GW-1:0] gen;
   logic [GW-1:0] prop;
   logic [GW:0]   carry;

   cla2_bit_pg #(.W(GW)) u_pg (
      .a   (a),
      .b   (b),
      .gen (gen),
      .prop(prop)
   );

   cla2_lookahead #(.N(GW)) u_l1 (
      .gen  (gen),
      .prop (prop),
      .c0   (cin),
      .c    (carry),
      .blk_p(grp_p),
      .blk_g(grp_g)
   );

   assign sum   = prop ^ carry[GW-1:0];
   assign c_msb = carry[GW-1];
   assign c_out = carry[GW];
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder #(
   parameter int WIDTH   = 16,
   parameter int GROUP_W = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   import cla2_pkg::*;

   localparam int NGROUPS = WIDTH / GROUP_W;

   generate
      if (GROUP_W < 1 || GROUP_W > CLA2_MAX_SPAN) begin : g_bad_gw
         $error("cla2_adder: GROUP_W out of range");
      end
      if (WIDTH % GROUP_W != 0) begin : g_bad_split
         $error("cla2_adder: WIDTH must be a multiple of GROUP_W");
      end
      if (NGROUPS < 1 || NGROUPS > CLA2_MAX_SPAN) begin : g_bad_ng
         $error("cla2_adder: group count out of range");
      end
   endgenerate

   logic [NGROUPS-1:0] grp_p;
   logic [NGROUPS-1:0] grp_g;
   logic [NGROUPS-1:0] grp_cmsb;
   logic [NGROUPS-1:0] grp_cout;
   logic [NGROUPS:0]   gcarry;

   for (genvar k = 0; k < NGROUPS; k++) begin : g_grp
      localparam int LO = k * GROUP_W;
      localparam int HI = LO + GROUP_W - 1;

      cla2_group #(.GW(GROUP_W)) u_grp (
         .a    (a[HI:LO]),
         .b    (b[HI:LO]),
         .cin  (gcarry[k]),
         .sum  (sum[HI:LO]),
         .grp_p(grp_p[k]),
         .grp_g(grp_g[k]),
         .c_msb(grp_cmsb[k]),
         .c_out(grp_cout[k])
      );

      always_comb begin
         // Local flattened carry-out agrees with the second-level carry.
         assert_grp_carry_R4: assert (grp_cout[k] == gcarry[k+1])
            else $error("group %0d carry-out disagrees with lookahead", k);
         assert_msb_step_R4: assert (!(grp_cmsb[k] && (a[HI] | b[HI])) || grp_cout[k])
            else $error("group %0d msb carry lost", k);
      end
   end

   generate
      if (NGROUPS > 1) begin : g_two_level
         logic top_p;
         logic top_g;
         cla2_lookahead #(.N(NGROUPS)) u_l2 (
            .gen  (grp_g),
            .prop (grp_p),
            .c0   (cin),
            .c    (gcarry),
            .blk_p(top_p),
            .blk_g(top_g)
         );
         always_comb begin
            assert_top_gen_R6: assert (!top_g || cout)
               else $error("word generate without carry-out");
            assert_top_prop_R5: assert (!top_p || (cout == cin))
               else $error("word propagate but carry-out differs from carry-in");
         end
      end else begin : g_one_level
         assign gcarry[0] = cin;
         assign gcarry[1] = grp_g[0] | (grp_p[0] & cin);
      end
   endgenerate

   assign cout = gcarry[NGROUPS];
   assign ovf  = grp_cmsb[NGROUPS-1] ^ cout;

   always_comb begin
      assert_ovf_sign_R3: assert (ovf == ((a[WIDTH-1] == b[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1])))
         else $error("overflow flag disagrees with operand and result signs");
   end
endmodule

// File: tb/cla2_adder_bench.sv
module cla2_adder_bench;
   localparam int W = 16;

   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         ci;
      logic [W-1:0] s;
      logic         co;
      logic         ov;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t TABLE [NVEC] = '{
      '{16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0},
      '{16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0},
      '{16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0},
      '{16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1},
      '{16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1},
      '{16'h8000, 16'hFFFF, 1'b0, 16'h7FFF, 1'b1, 1'b1},
      '{16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 1'b0},
      '{16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0, 1'b0},
      '{16'h0FFF, 16'h0000, 1'b1, 16'h1000, 1'b0, 1'b0},
      '{16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b0},
      '{16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, 1'b0},
      '{16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, 1'b0},
      '{16'h7FFF, 16'h7FFF, 1'b1, 16'hFFFF, 1'b0, 1'b1},
      '{16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;
   logic         ovf;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cla2_adder #(.WIDTH(W), .GROUP_W(4)) u_cla2_adder (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
   );

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h cin=%b: got %h expected %h", tag, a, b, cin, got, exp);
      end
   endtask

   // Behavioural model: full unsigned sum and sign rule.
   task automatic check_model(input string tag);
      logic [W:0] full;
      logic       ov_e;
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      ov_e = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
      check({tag, "/R1 sum"}, sum, full[W-1:0]);
      check({tag, "/R2 cout"}, {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, full[W]});
      check({tag, "/R3 ovf"}, {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, ov_e});
   endtask

   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
      @(negedge clk);
      a = av; b = bv; cin = cv;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected at most 100000", cycles);
         finish_run();
      end
   end

   initial begin
      // Reset state: zero operands give zero outputs (R1).
      repeat (2) @(negedge clk);
      #1;
      check("R1 reset sum", sum, '0);
      check("R2 reset cout", {{(W-1){1'b0}}, cout}, '0);
      check("R3 reset ovf", {{(W-1){1'b0}}, ovf}, '0);
      rst = 1'b0;

      // Table walk: R1 sum, R2 cout, R3 ovf.
      for (int i = 0; i < NVEC; i++) begin
         apply(TABLE[i].a, TABLE[i].b, TABLE[i].ci);
         check("R1 table sum", sum, TABLE[i].s);
         check("R2 table cout", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, TABLE[i].co});
         check("R3 table ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, TABLE[i].ov});
      end

      // R4: carries crossing each group boundary.
      for (int k = 1; k < 4; k++) begin
         apply((16'h1 << (4 * k)) - 16'h1, 16'h0001, 1'b0);
         check_model("R4 boundary");
         apply((16'h1 << (4 * k)) - 16'h1, 16'h0000, 1'b1);
         check_model("R4 boundary cin");
      end

      // R5: every bit propagates, carry-in passes through to cout.
      apply(16'h0F0F, 16'hF0F0, 1'b1);
      check("R5 prop sum", sum, 16'h0000);
      check("R5 prop cout", {{(W-1){1'b0}}, cout}, 16'h0001);
      apply(16'h0F0F, 16'hF0F0, 1'b0);
      check("R5 prop sum0", sum, 16'hFFFF);
      check("R5 prop cout0", {{(W-1){1'b0}}, cout}, 16'h0000);

      // R6: top group generates; carry-out independent of lower carries.
      apply(16'hF000, 16'h1000, 1'b0);
      check("R6 gen cout", {{(W-1){1'b0}}, cout}, 16'h0001);
      check("R6 gen sum", sum, 16'h0000);
      apply(16'h8000, 16'h8FFF, 1'b1);
      check_model("R6 gen cin");

      // R7: longest carry path.
      apply(16'hFFFF, 16'h0001, 1'b0);
      check("R7 ripple sum", sum, 16'h0000);
      check("R7 ripple cout", {{(W-1){1'b0}}, cout}, 16'h0001);
      apply(16'h0001, 16'hFFFF, 1'b1);
      check("R7 ripple sum cin", sum, 16'h0001);
      check("R7 ripple cout cin", {{(W-1){1'b0}}, cout}, 16'h0001);

      // R8: outputs follow inputs with no clock edge in between.
      @(negedge clk);
      a = 16'h0100; b = 16'h0023; cin = 1'b0;
      #1;
      check("R8 comb first", sum, 16'h0123);
      a = 16'h2000; b = 16'h0045; cin = 1'b1;
      #0.5;
      check("R8 comb second", sum, 16'h2046);

      // Random operands against the behavioural model.
      for (int n = 0; n < 10000; n++) begin
         apply(16'($urandom), 16'($urandom), 1'($urandom));
         check_model("rand");
      end

      finish_run();
   end
endmodule